// File: doc/BRIEF.md
# Background Memory Scrub Scheduler

This block issues background read requests that sweep every row of a protected memory array, one row at a time and in ascending order. A scrub read lets the downstream decoder find correctable errors that normal traffic has not touched, so that corrected data can be written back before a second upset lands in the same word. Scrub reads are spaced in time by a programmable interval. A credit counter is loaded on each granted scrub and counts down once per clock. When it runs out, a request becomes pending and stays pending until a port cycle is free.

Scrubbing always gives way to regular traffic. A regular read blocks it. In single-port mode a regular write blocks it as well. It also pauses while the correction buffer has no room. While blocked, the counter is not decremented further, so it cannot underflow. The request simply waits. With an interval of 0 or 1, a scrub is offered on every free cycle. A full sweep of a DEPTH-row array therefore takes at least DEPTH × interval cycles.

The controller has three states:
- `ST_OFF`: scrubbing is disabled.
- `ST_WAIT`: the credit counter is running.
- `ST_READY`: a scrub is pending.

The transitions are:
- `OFF→WAIT` or `OFF→READY` when the enable input is seen high. The target is `READY` when the interval is at most 1.
- `WAIT→READY` when the counter reaches its last credit.
- `READY→WAIT` on a granted scrub. The state stays `READY` instead when the interval is at most 1.
- Any state goes to `OFF` when the enable input is low.

Top module: `scrub_sched`

## Requirements
- R1: While reset is active and on the first cycle after it, scrub_req and scrub_tag are 0 and scrub_row is 0.
- R2: While scrub_en is 0, scrub_req is 0 in that same cycle.
- R3: With interval N ≥ 2 and no blocking, granted scrubs occur exactly N cycles apart.
- R4: With interval 0 or 1 and no blocking, scrub_req is 1 on every cycle and each grant advances the row.
- R5: A regular read (rd_req=1) forces scrub_req to 0 in the same cycle. The pending scrub is kept, the counter never goes below zero, and the scrub is offered on the first unblocked cycle.
- R6: A regular write (wr_req=1) forces scrub_req to 0 only when single_port=1. When single_port=0, a write has no effect on scrub_req.
- R7: While cbuf_full=1, scrub_req is 0 and the pending scrub is kept.
- R8: scrub_row advances by one only in a cycle where scrub_req and scrub_grant are both 1. An ungranted request keeps its row and stays pending.
- R9: scrub_row wraps from DEPTH-1 to 0.
- R10: One cycle after a granted scrub, scrub_tag is 1 and tag_row holds the row that was granted. Otherwise scrub_tag is 0.
- R11: When scrub_en rises, the counter is reloaded from the interval. The first request appears N cycles after the first cycle enable is seen high (N ≥ 1).
- R12: The interval is sampled only when the counter is loaded, which happens on enable or on a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scrub_en | input | 1 | Scrubbing enable |
| scrub_interval | input | IVL_W | Cycles between scrub reads |
| single_port | input | 1 | 1: writes also block scrubbing |
| rd_req | input | 1 | Regular read request this cycle |
| wr_req | input | 1 | Regular write request this cycle |
| cbuf_full | input | 1 | Correction buffer has no free entry |
| scrub_grant | input | 1 | Arbiter accepts the scrub read this cycle |
| scrub_req | output | 1 | Scrub read request |
| scrub_row | output | AW | Row address of the scrub request |
| scrub_tag | output | 1 | Marks that the read issued last cycle was a scrub |
| tag_row | output | AW | Row of the tagged scrub read |

## Verification
The assertions assume that the enable, interval, mode, regular-request and buffer-full inputs are clean synchronous levels held over a whole cycle. They also assume that scrub_grant is meaningful only when a request is present. The bench changes every input on the falling edge, so each value is stable across the rising edge. It drives scrub_grant both high and low, including while no request is pending. This shows that a stray grant neither moves the row nor raises the tag. The interval is changed only between phases, with one exception: a deliberate change while the counter is running, to exercise R12.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } scrub_state_e;
endpackage

// File: rtl/scrub_gate.sv
module scrub_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic single_port,
    input  logic cbuf_full,
    output logic port_free
);
    logic wr_blocks;

    always_comb begin
        wr_blocks = single_port & wr_req;
        port_free = ~rd_req & ~wr_blocks & ~cbuf_full;
    end

    // R7: a full correction buffer never leaves the scrub path open
    assert_cbuf_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cbuf_full |-> !port_free);
endmodule

// File: rtl/scrub_credit.sv
module scrub_credit #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IVL_W-1:0] load_val,
    input  logic             dec,
    output logic [IVL_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        last = (cnt == IVL_W'(1));
    end

    // R5: the counter is never stepped below zero
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt != '0);
endmodule

// File: rtl/scrub_row_ptr.sv
module scrub_row_ptr #(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] row,
    output logic          tag,
    output logic [AW-1:0] tag_row
);
    localparam logic [AW-1:0] LAST_ROW = AW'(DEPTH - 1);
    logic [AW-1:0] row_inc;

    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            always_comb row_inc = row + 1'b1;
        end else begin : g_odd
            always_comb row_inc = (row == LAST_ROW) ? '0 : row + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row     <= '0;
            tag     <= 1'b0;
            tag_row <= '0;
        end else begin
            tag <= adv;
            if (adv) begin
                row     <= row_inc;
                tag_row <= row;
            end
        end
    end

    // R8: the row only moves on a granted scrub
    assert_row_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row));
    // R9: wrap from the last row back to zero
    assert_row_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && row == LAST_ROW) |=> row == '0);
    // R10: the tag carries the row just granted
    assert_tag_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (tag && tag_row == $past(row)));
endmodule

// File: rtl/scrub_sched.sv
module scrub_sched #(
    parameter int DEPTH = 16,
    parameter int IVL_W = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scrub_en,
    input  logic [IVL_W-1:0] scrub_interval,
    input  logic             single_port,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             cbuf_full,
    input  logic             scrub_grant,
    output logic             scrub_req,
    output logic [AW-1:0]    scrub_row,
    output logic             scrub_tag,
    output logic [AW-1:0]    tag_row
);
    import scrub_pkg::*;

    scrub_state_e     state_q, state_d;
    logic             port_free;
    logic             fire;
    logic             long_ivl;
    logic             ld;
    logic             dec;
    logic [IVL_W-1:0] ld_val;
    logic [IVL_W-1:0] cnt;
    logic             cnt_last;

    scrub_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .single_port (single_port),
        .cbuf_full   (cbuf_full),
        .port_free   (port_free)
    );

    scrub_credit #(.IVL_W(IVL_W)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .dec      (dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    scrub_row_ptr #(.DEPTH(DEPTH), .AW(AW)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (fire),
        .row     (scrub_row),
        .tag     (scrub_tag),
        .tag_row (tag_row)
    );

    always_comb begin
        long_ivl = scrub_interval > IVL_W'(1);
        ld_val   = long_ivl ? scrub_interval - 1'b1 : '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        scrub_req = (state_q == ST_READY) & scrub_en & port_free;
        fire      = scrub_req & scrub_grant;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        dec     = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (scrub_en) begin
                    ld      = 1'b1;
                    state_d = long_ivl ? ST_WAIT : ST_READY;
                end
            end
            ST_WAIT: begin
                if (!scrub_en)     state_d = ST_OFF;
                else if (cnt_last) state_d = ST_READY;
                else               dec     = 1'b1;
            end
            ST_READY: begin
                if (!scrub_en) begin
                    state_d = ST_OFF;
                end else if (fire) begin
                    ld      = 1'b1;
                    state_d = long_ivl ? ST_WAIT : ST_READY;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // R2: no request while disabled
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !scrub_en |-> !scrub_req);
    // R5: regular reads always win
    assert_read_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !scrub_req);
    // R6: writes win in single-port mode
    assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (single_port && wr_req) |-> !scrub_req);
    // R5: a blocked pending scrub is kept
    assert_pending_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && scrub_en && !fire) |=> state_q == ST_READY);
    // R3: a counting state always holds credit
    assert_wait_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> cnt != '0);
endmodule

// File: tb/scrub_sched_tb.sv
module scrub_sched_tb;
    localparam int DEPTH = 16;
    localparam int IVL_W = 8;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sp = 1'b0, rd = 1'b0, wr = 1'b0, cf = 1'b0, gnt = 1'b0;
    logic [IVL_W-1:0] iv = '0;
    logic scrub_req, scrub_tag;
    logic [AW-1:0] scrub_row, tag_row;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    bit m_active = 0;
    int m_wait = 0;
    int m_row = 0;
    bit m_tag = 0;
    int m_tagrow = 0;

    always #5 clk = ~clk;

    scrub_sched #(.DEPTH(DEPTH), .IVL_W(IVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .scrub_en(en), .scrub_interval(iv),
        .single_port(sp), .rd_req(rd), .wr_req(wr), .cbuf_full(cf),
        .scrub_grant(gnt), .scrub_req(scrub_req), .scrub_row(scrub_row),
        .scrub_tag(scrub_tag), .tag_row(tag_row)
    );

    function automatic bit exp_req();
        return en && m_active && (m_wait == 0) && !cf && !rd && !(sp && wr);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_wait = 0; m_row = 0; m_tag = 0; m_tagrow = 0;
        end else begin
            bit f;
            f = exp_req() && gnt;
            m_tag = f;
            if (f) m_tagrow = m_row;
            if (!en) m_active = 0;
            else if (!m_active) begin
                m_active = 1;
                m_wait = (iv > 1) ? int'(iv) - 1 : 0;
            end else if (m_wait > 0) m_wait--;
            else if (f) begin
                m_wait = (iv > 1) ? int'(iv) - 1 : 0;
                m_row = (m_row + 1) % DEPTH;
            end
        end
    end

    task automatic check(input string rq, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step(input bit e, input bit r, input bit w, input bit s, input bit c, input bit g);
        @(negedge clk);
        en = e; rd = r; wr = w; sp = s; cf = c; gnt = g;
        #1;
        check(cur_req, "req", int'(scrub_req), int'(exp_req()));
        check(cur_req, "row", int'(scrub_row), m_row);
        check(cur_req, "tag", int'(scrub_tag), int'(m_tag));
        if (m_tag) check(cur_req, "tag_row", int'(tag_row), m_tagrow);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int last_fire;
        int first;
        int row0;
        bit wrapped;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "req in reset", int'(scrub_req), 0);
        check("R1", "tag in reset", int'(scrub_tag), 0);
        check("R1", "row in reset", int'(scrub_row), 0);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1";
        step(0, 0, 0, 0, 0, 1);

        // R2 disabled, grant high
        cur_req = "R2"; iv = 8'd3;
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 0, 0, 0, 1);
            check("R2", "req while off", int'(scrub_req), 0);
        end

        // R3 spacing with interval 4, R11 first request delay
        cur_req = "R3"; iv = 8'd4;
        last_fire = -1; first = -1;
        for (int i = 0; i < 40; i++) begin
            step(1, 0, 0, 0, 0, 1);
            if (scrub_req) begin
                if (first < 0) first = i;
                if (last_fire >= 0) check("R3", "scrub spacing", i - last_fire, 4);
                last_fire = i;
            end
        end
        check("R11", "first request delay", first, 4);

        // R12 interval changed while counting is not picked up until reload
        cur_req = "R12";
        iv = 8'd6;
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 0, 1);

        // R4 interval 0 and 1: every free cycle
        cur_req = "R4";
        for (int k = 0; k < 2; k++) begin
            iv = IVL_W'(k);
            for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, 1);
            for (int i = 0; i < 10; i++) begin
                step(1, 0, 0, 0, 0, 1);
                check("R4", "req every cycle", int'(scrub_req), 1);
            end
        end

        // R5 read traffic blocks, pending kept
        cur_req = "R5"; iv = 8'd2;
        for (int i = 0; i < 200; i++) step(1, ($urandom % 3) != 0, 0, 0, 0, 1);
        for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 1);
        check("R5", "scrub after long block", int'(scrub_req), 1);

        // R6 writes: no effect in dual port, block in single port
        cur_req = "R6";
        for (int i = 0; i < 60; i++) begin
            step(1, 0, 1, 0, 0, 1);
        end
        iv = 8'd0;
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 1);
        check("R6", "dual-port write ignored", int'(scrub_req), 1);
        step(1, 0, 1, 1, 0, 1);
        check("R6", "single-port write blocks", int'(scrub_req), 0);
        iv = 8'd3;
        for (int i = 0; i < 100; i++) step(1, 0, $urandom % 2, 1, 0, 1);

        // R7 buffer full pause
        cur_req = "R7";
        for (int i = 0; i < 100; i++) step(1, 0, 0, 0, ($urandom % 2) == 0, 1);
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 0, 0, 1, 1);
            check("R7", "paused when full", int'(scrub_req), 0);
        end

        // R8 grant withheld
        cur_req = "R8"; iv = 8'd0;
        step(1, 0, 0, 0, 0, 0);
        row0 = int'(scrub_row);
        step(1, 0, 0, 0, 0, 0);
        check("R8", "row held without grant", int'(scrub_row), row0);
        check("R8", "still pending", int'(scrub_req), 1);
        for (int i = 0; i < 150; i++) step(1, ($urandom % 4) == 0, 0, 0, 0, $urandom % 2);

        // R9 wrap, R10 tag checked by model on every step
        cur_req = "R9"; iv = 8'd0;
        wrapped = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            step(1, 0, 0, 0, 0, 1);
            if (scrub_row == AW'(DEPTH - 1)) begin
                step(1, 0, 0, 0, 0, 1);
                check("R9", "wrap to zero", int'(scrub_row), 0);
                check("R10", "tag row at wrap", int'(tag_row), DEPTH - 1);
                wrapped = 1;
            end
        end
        check("R9", "wrap seen", int'(wrapped), 1);

        // R11 re-enable reloads
        cur_req = "R11"; iv = 8'd5;
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1);
        first = -1;
        for (int i = 0; i < 12; i++) begin
            step(1, 0, 0, 0, 0, 1);
            if (scrub_req && first < 0) first = i;
        end
        check("R11", "delay after re-enable", first, 5);

        // mixed traffic
        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) iv = IVL_W'($urandom % 5);
            step(($urandom % 20) != 0, ($urandom % 4) == 0, $urandom % 2,
                 $urandom % 2, ($urandom % 6) == 0, ($urandom % 4) != 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule